// File: doc/BRIEF.md
# Queued Command Issue Controller

This block sits in a host bus adapter between host software and the frame transmitter. Software offers a queued command as a tag on a valid/ready request port. The block checks the tag against the queue depth captured at reset and against the set of commands still outstanding. An invalid or repeated tag gets a one-cycle error pulse. A valid tag is held until the device status busy flag reads zero. The block then marks the tag in a 32-bit outstanding register and, one cycle later, sends a one-cycle launch strobe that carries the tag to the frame transmitter.

Outstanding bits are cleared from outside through a completion mask. A completion may clear several tags at once. Only one request is in flight inside the block at a time, so a second request waits at the ready signal until the current one has launched.

Top module: `qcmd_issue_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `active` is all zero, `launch_valid` and `req_err` are low, and `req_ready` is high.
- R2: A request with a valid tag that is accepted at a clock edge, with `dev_busy` low at the next edge, sets `active[tag]` after that next edge. `launch_valid` then rises one cycle later for exactly one cycle, with `launch_tag` equal to the tag.
- R3: While a request is pending and `dev_busy` is high, no outstanding bit is set and no launch happens. The bit is set at the first edge at which `dev_busy` is low.
- R4: When `launch_valid` is high, the outstanding bit of `launch_tag` was already set in the previous cycle.
- R5: A tag equal to or greater than the captured depth is rejected. `req_err` is high for the one cycle after the acceptance edge, and no launch occurs. `active` is unchanged.
- R6: A tag whose outstanding bit is already set is rejected in the same way as R5. It is never launched twice.
- R7: `cfg_depth` (legal range 1 to 32) is captured while `rst` is high. Later changes to it have no effect until the next reset.
- R8: When `cpl_valid` is high at an edge, every `active` bit whose `cpl_mask` bit is one is cleared.
- R9: If a completion clears the bit that is being set at the same edge, that bit ends up set. The other masked bits are still cleared.
- R10: `req_ready` is low from the acceptance edge of a valid request until the edge at which `launch_valid` rises.
- R11: `launch_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_depth | input | 6 | Maximum queue depth, captured during reset |
| req_valid | input | 1 | Command request offered |
| req_tag | input | 5 | Tag of the offered command |
| req_ready | output | 1 | Block can accept a request |
| req_err | output | 1 | One-cycle pulse: request rejected |
| dev_busy | input | 1 | Device status busy flag |
| cpl_valid | input | 1 | Completion mask is valid this cycle |
| cpl_mask | input | 32 | Tags to clear from the outstanding register |
| active | output | 32 | Outstanding-command register |
| launch_valid | output | 1 | One-cycle launch strobe toward the frame transmitter |
| launch_tag | output | 5 | Tag of the launched command |

## Verification
Two functions can act on the outstanding register at the same edge: setting a newly issued tag and clearing bits from a completion mask. The bench provokes this by raising `cpl_valid` in the cycle where the pending tag is about to be marked. The mask covers both that tag and an older outstanding tag. The result is judged from `active` after the edge: the new tag must be set and the older one cleared. A second overlap is a busy deferral that ends exactly when the bit is set. It is judged by checking that the bit appears on the first edge with `dev_busy` low and not before.

// File: rtl/qcmd_pkg.sv
package qcmd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_PEND   = 2'd1,
    ST_LAUNCH = 2'd2
  } issue_state_t;
endpackage

// File: rtl/qcmd_tag_check.sv
module qcmd_tag_check #(
  parameter int NTAG = 32,
  localparam int TAG_W = $clog2(NTAG),
  localparam int DEPTH_W = TAG_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic [TAG_W-1:0]   tag,
  input  logic [NTAG-1:0]    active,
  output logic               tag_ok
);
  logic [DEPTH_W-1:0] depth_q;

  // depth is captured only while reset is held
  always_ff @(posedge clk) begin
    if (rst) depth_q <= cfg_depth;
  end

  always_comb begin
    tag_ok = (DEPTH_W'(tag) < depth_q) && !active[tag];
  end
endmodule

// File: rtl/qcmd_outstanding.sv
module qcmd_outstanding #(
  parameter int NTAG = 32,
  localparam int TAG_W = $clog2(NTAG)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             cpl_valid,
  input  logic [NTAG-1:0]  cpl_mask,
  output logic [NTAG-1:0]  active
);
  for (genvar i = 0; i < NTAG; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        active[i] <= 1'b0;
      else if (set_en && set_tag == TAG_W'(i))
        active[i] <= 1'b1;
      else if (cpl_valid && cpl_mask[i])
        active[i] <= 1'b0;
    end
  end

  // R6
  unique_tag_chk: assert property (@(posedge clk) disable iff (rst)
    set_en |-> !active[set_tag]);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (active == '0));
endmodule

// File: rtl/qcmd_issue_fsm.sv
module qcmd_issue_fsm
  import qcmd_pkg::*;
#(
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             tag_ok,
  input  logic             dev_busy,
  output logic             req_ready,
  output logic             req_err,
  output logic             set_en,
  output logic [TAG_W-1:0] tag_q,
  output logic             launch_valid
);
  issue_state_t state_q;

  always_comb begin
    req_ready = (state_q == ST_IDLE);
    set_en    = (state_q == ST_PEND) && !dev_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      req_err      <= 1'b0;
      launch_valid <= 1'b0;
      tag_q        <= '0;
    end else begin
      req_err      <= 1'b0;
      launch_valid <= 1'b0;
      case (state_q)
        ST_IDLE: if (req_valid) begin
          tag_q <= req_tag;
          if (tag_ok) state_q <= ST_PEND;
          else        req_err <= 1'b1;
        end
        ST_PEND: if (!dev_busy) state_q <= ST_LAUNCH;
        ST_LAUNCH: begin
          launch_valid <= 1'b1;
          state_q      <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R11
  launch_once_chk: assert property (@(posedge clk) disable iff (rst)
    launch_valid |=> !launch_valid);
endmodule

// File: rtl/qcmd_issue_ctrl.sv
module qcmd_issue_ctrl #(
  parameter int NTAG = 32,
  localparam int TAG_W = $clog2(NTAG),
  localparam int DEPTH_W = TAG_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DEPTH_W-1:0] cfg_depth,
  input  logic               req_valid,
  input  logic [TAG_W-1:0]   req_tag,
  output logic               req_ready,
  output logic               req_err,
  input  logic               dev_busy,
  input  logic               cpl_valid,
  input  logic [NTAG-1:0]    cpl_mask,
  output logic [NTAG-1:0]    active,
  output logic               launch_valid,
  output logic [TAG_W-1:0]   launch_tag
);
  logic             tag_ok;
  logic             set_en;
  logic [TAG_W-1:0] tag_q;

  qcmd_tag_check #(.NTAG(NTAG)) u_check (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth),
    .tag(req_tag), .active(active), .tag_ok(tag_ok)
  );

  qcmd_issue_fsm #(.TAG_W(TAG_W)) u_fsm (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_tag(req_tag),
    .tag_ok(tag_ok), .dev_busy(dev_busy), .req_ready(req_ready),
    .req_err(req_err), .set_en(set_en), .tag_q(tag_q),
    .launch_valid(launch_valid)
  );

  qcmd_outstanding #(.NTAG(NTAG)) u_out (
    .clk(clk), .rst(rst), .set_en(set_en), .set_tag(tag_q),
    .cpl_valid(cpl_valid), .cpl_mask(cpl_mask), .active(active)
  );

  assign launch_tag = tag_q;

  // R4
  set_before_launch_chk: assert property (@(posedge clk) disable iff (rst)
    launch_valid |-> $past(active[launch_tag]));

  // R3
  busy_gate_chk: assert property (@(posedge clk) disable iff (rst)
    launch_valid |-> !$past(dev_busy, 2));
endmodule

// File: tb/sim_qcmd_issue_ctrl.sv
module sim_qcmd_issue_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  cfg_depth = 6'd16;
  logic        req_valid = 1'b0;
  logic [4:0]  req_tag = '0;
  logic        req_ready, req_err;
  logic        dev_busy = 1'b0;
  logic        cpl_valid = 1'b0;
  logic [31:0] cpl_mask = '0;
  logic [31:0] active;
  logic        launch_valid;
  logic [4:0]  launch_tag;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_active = '0;

  always #4 clk = ~clk;

  qcmd_issue_ctrl u0 (
    .clk(clk), .rst(rst), .cfg_depth(cfg_depth), .req_valid(req_valid),
    .req_tag(req_tag), .req_ready(req_ready), .req_err(req_err),
    .dev_busy(dev_busy), .cpl_valid(cpl_valid), .cpl_mask(cpl_mask),
    .active(active), .launch_valid(launch_valid), .launch_tag(launch_tag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [5:0] depth);
    rst = 1'b1; cfg_depth = depth;
    repeat (3) step();
    rst = 1'b0;
    step();
    exp_active = '0;
    chk("R1 active", active, 32'h0);
    chk("R1 launch", {31'b0, launch_valid}, 32'h0);
    chk("R1 err", {31'b0, req_err}, 32'h0);
    chk("R1 ready", {31'b0, req_ready}, 32'h1);
  endtask

  task automatic issue_ok(input logic [4:0] tag);
    req_valid = 1'b1; req_tag = tag;
    step();
    req_valid = 1'b0;
    chk("R10 ready low", {31'b0, req_ready}, 32'h0);
    chk("R2 not yet set", active, exp_active);
    step();
    exp_active[tag] = 1'b1;
    chk("R2 bit set", active, exp_active);
    chk("R4 no launch before set", {31'b0, launch_valid}, 32'h0);
    step();
    chk("R2 launch", {31'b0, launch_valid}, 32'h1);
    chk("R2 launch tag", {27'b0, launch_tag}, {27'b0, tag});
    step();
    chk("R11 single pulse", {31'b0, launch_valid}, 32'h0);
  endtask

  task automatic issue_bad(input logic [4:0] tag, input string req);
    req_valid = 1'b1; req_tag = tag;
    step();
    req_valid = 1'b0;
    chk({req, " err pulse"}, {31'b0, req_err}, 32'h1);
    chk({req, " active unchanged"}, active, exp_active);
    chk({req, " ready"}, {31'b0, req_ready}, 32'h1);
    step();
    chk({req, " err ends"}, {31'b0, req_err}, 32'h0);
    chk({req, " no launch"}, {31'b0, launch_valid}, 32'h0);
    step();
    chk({req, " still no launch"}, {31'b0, launch_valid}, 32'h0);
  endtask

  task automatic t_busy();
    dev_busy = 1'b1;
    req_valid = 1'b1; req_tag = 5'd3;
    step();
    req_valid = 1'b0;
    repeat (4) begin
      step();
      chk("R3 deferred bit", active, exp_active);
      chk("R3 deferred launch", {31'b0, launch_valid}, 32'h0);
    end
    dev_busy = 1'b0;
    step();
    exp_active[3] = 1'b1;
    chk("R3 set after busy", active, exp_active);
    step();
    chk("R3 launch after busy", {31'b0, launch_valid}, 32'h1);
    step();
  endtask

  task automatic t_complete(input logic [31:0] mask);
    cpl_valid = 1'b1; cpl_mask = mask;
    step();
    cpl_valid = 1'b0; cpl_mask = '0;
    exp_active = exp_active & ~mask;
    chk("R8 completion clears", active, exp_active);
  endtask

  task automatic t_collision();
    req_valid = 1'b1; req_tag = 5'd7;
    step();
    req_valid = 1'b0;
    cpl_valid = 1'b1; cpl_mask = (32'h1 << 7) | (32'h1 << 2);
    step();
    cpl_valid = 1'b0; cpl_mask = '0;
    exp_active[2] = 1'b0;
    exp_active[7] = 1'b1;
    chk("R9 issue wins, other cleared", active, exp_active);
    step();
    chk("R9 launch", {31'b0, launch_valid}, 32'h1);
    step();
  endtask

  initial begin
    do_reset(6'd16);
    cfg_depth = 6'd32;
    issue_ok(5'd5);
    issue_ok(5'd2);
    issue_ok(5'd15);
    issue_bad(5'd16, "R5/R7 tag above depth");
    issue_bad(5'd31, "R5 tag 31 with depth 16");
    issue_bad(5'd5, "R6 duplicate");
    t_busy();
    t_complete((32'h1 << 5) | (32'h1 << 15));
    issue_ok(5'd5);
    t_collision();
    do_reset(6'd32);
    issue_ok(5'd31);
    issue_ok(5'd0);
    t_complete(32'hFFFF_FFFF);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule